// File: doc/BRIEF.md
# SDRAM Bank Auto-Precharge Timing Tracker

This block shadows the command stream of an SDRAM controller and keeps, for every bank, a model of the internal precharge that follows a read or write with auto-precharge. Each cycle it takes one command and a bank index. It also takes the static burst-length, CAS-latency, single-write, tRP and tRAS settings. From these it works out the cycle in which the bank's internal precharge starts and the cycle from which the bank may be activated again.

Per bank it drives a ready bit and a one-cycle pulse that marks the start of the internal precharge. A command that breaks the bank rules sets a sticky violation flag and records the offending bank. The first offence is held until a synchronous clear. The block drives no DRAM pins and moves no data. The write mask input is accepted only so that the precharge timing can be shown to ignore it.

Top module: `ap_bank_tracker`

## Requirements
- R1: After reset every bank is idle: ready_o is all ones, pre_start_o is all zeros and viol_o is low.
- R2: Command codes on cmd_i are 0 no-op, 1 activate, 2 read with auto-precharge and 3 write with auto-precharge. An activate to a bank whose ready bit is high opens it, and its ready bit is low from the next cycle. An activate to a bank whose ready bit is low is a violation.
- R3: Burst length code bl_sel_i is 0, 1, 2 or 3 for bursts of 1, 2, 4 or 8. For a read with auto-precharge, pre_start_o of the bank pulses BL clocks after the command. The next activate is legal exactly BL+tRP clocks after the command, and ready_o of the bank is high in the cycle before that edge. One clock earlier the activate is a violation.
- R4: For a write with auto-precharge, the precharge starts CL-1 clocks after the last data beat, which is BL+CL-2 clocks after the command (cl3_i=1 selects CL=3, otherwise CL=2). The bank is released BL+tRP clocks after the command at CL=2 and BL+1+tRP clocks after it at CL=3.
- R5: dqm_i has no effect on any precharge start or release time.
- R6: A bl_sel_i code of 4 or above selects full-page bursts. In that mode a read or write with auto-precharge leaves the bank open: ready stays low, no precharge pulse occurs and no violation is raised.
- R7: When single_wr_i is high, writes use a burst of 1 for the auto-precharge timing. This also applies in full-page mode, where the write then does auto-precharge.
- R8: Any command to a bank that is auto-precharging and not yet released is a violation. A read or write to a bank that is not open is also a violation.
- R9: If an auto-precharge command makes the internal precharge start fewer than tRAS clocks after the bank's activate, it is a violation. At exactly tRAS clocks it is legal.
- R10: viol_o is sticky and viol_bank_o holds the bank of the first violation. clr_i clears the flag on the next edge. A violation in the same cycle as clr_i is captured.
- R11: pre_start_o is a single-cycle pulse per auto-precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | Command code for this cycle |
| bank_i | input | BANK_W | Bank addressed by cmd_i |
| dqm_i | input | DQM_W | Write data mask (no timing effect) |
| bl_sel_i | input | 3 | Burst length code |
| single_wr_i | input | 1 | Burst read, single write mode |
| cl3_i | input | 1 | CAS latency 3 when high, 2 when low |
| trp_i | input | CNT_W | tRP(min) in clocks, at least 1 |
| tras_i | input | CNT_W | tRAS(min) in clocks |
| clr_i | input | 1 | Synchronous clear of the violation flag |
| ready_o | output | BANKS | Per bank: an activate is legal on the next edge |
| pre_start_o | output | BANKS | Per bank: internal precharge starts this cycle |
| viol_o | output | 1 | Sticky violation flag |
| viol_bank_o | output | BANK_W | Bank of the first violation |

## Verification
The assertions assume that the configuration inputs are static while any bank is open or precharging, and that trp_i is never zero. The bench changes bl_sel_i, cl3_i, single_wr_i, trp_i and tras_i only on a falling edge after every affected bank has been released. It keeps trp_i between 1 and 3. Commands are applied one per cycle on the falling edge and held for a single edge. The bench therefore never asserts a command outside the edges it intends.

// File: rtl/ap_pkg.sv
package ap_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RDA = 2'd2,
    CMD_WRA = 2'd3
  } ap_cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE = 2'd0,
    BK_OPEN = 2'd1,
    BK_APRE = 2'd2
  } bank_st_e;

  localparam int unsigned DLY_W = 4;

  // Beats for a non-full-page burst code
  function automatic logic [DLY_W-1:0] burst_beats(input logic [1:0] code);
    return DLY_W'(1) << code;
  endfunction
endpackage

// File: rtl/ap_timing_calc.sv
module ap_timing_calc
  import ap_pkg::*;
#(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned REL_W = CNT_W + 2
) (
  input  ap_cmd_e          cmd_i,
  input  logic [2:0]       bl_sel_i,
  input  logic             single_wr_i,
  input  logic             cl3_i,
  input  logic [CNT_W-1:0] trp_i,
  output logic             ap_en_o,
  output logic [DLY_W-1:0] start_o,
  output logic [REL_W-1:0] rel_m1_o
);
  logic             full_page;
  logic             is_wr;
  logic [DLY_W-1:0] beats;
  logic [DLY_W-1:0] wr_beats;

  assign full_page = bl_sel_i[2];
  assign is_wr     = (cmd_i == CMD_WRA);
  assign beats     = burst_beats(bl_sel_i[1:0]);
  assign wr_beats  = single_wr_i ? DLY_W'(1) : beats;

  always_comb begin
    ap_en_o = 1'b0;
    if (cmd_i == CMD_RDA) ap_en_o = !full_page;
    if (is_wr)            ap_en_o = !full_page || single_wr_i;
  end

  // write: last beat at BL-1, precharge CL-1 later
  assign start_o  = is_wr ? (wr_beats + DLY_W'(cl3_i)) : beats;
  assign rel_m1_o = REL_W'(start_o) + REL_W'(trp_i) - REL_W'(1);
endmodule

// File: rtl/ap_bank_fsm.sv
module ap_bank_fsm
  import ap_pkg::*;
#(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned REL_W = CNT_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  ap_cmd_e          cmd_i,
  input  logic             ap_en_i,
  input  logic [DLY_W-1:0] start_i,
  input  logic [REL_W-1:0] rel_m1_i,
  input  logic [CNT_W-1:0] trp_i,
  input  logic [CNT_W-1:0] tras_i,
  output logic             ready_o,
  output logic             pre_start_o,
  output logic             viol_o
);
  bank_st_e         st_q;
  logic [REL_W-1:0] cnt_q;
  logic [CNT_W-1:0] ras_q;
  logic             eff_idle;
  logic             is_ap_cmd;
  logic             ras_ok;
  logic             act_ok;
  logic             ap_ok;

  assign eff_idle  = (st_q == BK_IDLE) || (st_q == BK_APRE && cnt_q == '0);
  assign is_ap_cmd = (cmd_i == CMD_RDA) || (cmd_i == CMD_WRA);
  // precharge at start_i must be >= tRAS after activate; ras_q lags one edge
  assign ras_ok    = REL_W'(ras_q) <= REL_W'(start_i) + REL_W'(1);
  assign act_ok    = sel_i && cmd_i == CMD_ACT && eff_idle;
  assign ap_ok     = sel_i && is_ap_cmd && st_q == BK_OPEN && ap_en_i;

  assign ready_o     = eff_idle;
  assign pre_start_o = (st_q == BK_APRE) && (cnt_q == REL_W'(trp_i) - REL_W'(1));

  always_comb begin
    viol_o = 1'b0;
    if (sel_i) begin
      if (cmd_i == CMD_ACT) viol_o = !eff_idle;
      else if (is_ap_cmd)   viol_o = (st_q != BK_OPEN) || (ap_en_i && !ras_ok);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q <= '0;
    end else if (act_ok) begin
      ras_q <= tras_i;
    end else if (ras_q != '0) begin
      ras_q <= ras_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
    end else if (act_ok) begin
      st_q  <= BK_OPEN;
      cnt_q <= '0;
    end else if (ap_ok) begin
      st_q  <= BK_APRE;
      cnt_q <= rel_m1_i;
    end else if (st_q == BK_APRE) begin
      if (cnt_q == '0) st_q <= BK_IDLE;
      else             cnt_q <= cnt_q - REL_W'(1);
    end
  end

  assert_open_on_act_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && cmd_i == CMD_ACT && ready_o) |=> !ready_o);

  assert_busy_after_ap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && is_ap_cmd && ap_en_i && !ready_o && st_q == BK_OPEN) |=> !ready_o);

  assert_pre_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_start_o |=> !pre_start_o);
endmodule

// File: rtl/ap_viol_latch.sv
module ap_viol_latch #(
  parameter int unsigned BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [BANK_W-1:0] hit_bank_i,
  input  logic              clr_i,
  output logic              flag_o,
  output logic [BANK_W-1:0] bank_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      bank_o <= '0;
    end else if (hit_i && (!flag_o || clr_i)) begin
      flag_o <= 1'b1;
      bank_o <= hit_bank_i;
    end else if (clr_i) begin
      flag_o <= 1'b0;
    end
  end

  assert_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> (flag_o && $stable(bank_o)));

  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit_i) |=> !flag_o);

  assert_capture_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> flag_o);
endmodule

// File: rtl/ap_bank_tracker.sv
module ap_bank_tracker
  import ap_pkg::*;
#(
  parameter int unsigned BANKS  = 4,
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned DQM_W  = 4,
  parameter int unsigned BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [DQM_W-1:0]  dqm_i,
  input  logic [2:0]        bl_sel_i,
  input  logic              single_wr_i,
  input  logic              cl3_i,
  input  logic [CNT_W-1:0]  trp_i,
  input  logic [CNT_W-1:0]  tras_i,
  input  logic              clr_i,
  output logic [BANKS-1:0]  ready_o,
  output logic [BANKS-1:0]  pre_start_o,
  output logic              viol_o,
  output logic [BANK_W-1:0] viol_bank_o
);
  localparam int unsigned REL_W = CNT_W + 2;

  ap_cmd_e          cmd;
  logic             ap_en;
  logic [DLY_W-1:0] start;
  logic [REL_W-1:0] rel_m1;
  logic [BANKS-1:0] bank_viol;
  logic             unused_dqm;

  assign cmd        = ap_cmd_e'(cmd_i);
  // masks never shift precharge timing
  assign unused_dqm = ^dqm_i;

  ap_timing_calc #(.CNT_W(CNT_W), .REL_W(REL_W)) u_calc (
    .cmd_i       (cmd),
    .bl_sel_i    (bl_sel_i),
    .single_wr_i (single_wr_i),
    .cl3_i       (cl3_i),
    .trp_i       (trp_i),
    .ap_en_o     (ap_en),
    .start_o     (start),
    .rel_m1_o    (rel_m1)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (bank_i == BANK_W'(b)) && (cmd != CMD_NOP);

    ap_bank_fsm #(.CNT_W(CNT_W), .REL_W(REL_W)) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sel_i       (sel),
      .cmd_i       (cmd),
      .ap_en_i     (ap_en),
      .start_i     (start),
      .rel_m1_i    (rel_m1),
      .trp_i       (trp_i),
      .tras_i      (tras_i),
      .ready_o     (ready_o[b]),
      .pre_start_o (pre_start_o[b]),
      .viol_o      (bank_viol[b])
    );
  end

  ap_viol_latch #(.BANK_W(BANK_W)) u_viol (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (|bank_viol),
    .hit_bank_i (bank_i),
    .clr_i      (clr_i),
    .flag_o     (viol_o),
    .bank_o     (viol_bank_o)
  );

  assert_act_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_ACT && !ready_o[bank_i]) |=> viol_o);

  assert_no_viol_on_nop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_NOP && !viol_o && !clr_i) |=> !viol_o);
endmodule

// File: tb/ap_bank_tracker_tb.sv
`timescale 1ns/1ps
module ap_bank_tracker_tb;
  localparam int BANKS = 4;
  localparam int CNT_W = 6;
  localparam int NV    = 17;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic [1:0]       cmd_i;
  logic [1:0]       bank_i;
  logic [3:0]       dqm_i;
  logic [2:0]       bl_sel_i;
  logic             single_wr_i;
  logic             cl3_i;
  logic [CNT_W-1:0] trp_i;
  logic [CNT_W-1:0] tras_i;
  logic             clr_i;
  logic [BANKS-1:0] ready_o;
  logic [BANKS-1:0] pre_start_o;
  logic             viol_o;
  logic [1:0]       viol_bank_o;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  ap_bank_tracker #(.BANKS(BANKS), .CNT_W(CNT_W), .DQM_W(4)) u_dut (
    .clk_i, .rst_ni, .cmd_i, .bank_i, .dqm_i, .bl_sel_i, .single_wr_i,
    .cl3_i, .trp_i, .tras_i, .clr_i, .ready_o, .pre_start_o, .viol_o, .viol_bank_o
  );

  // {cmd, bank, ready[3:0], pre[3:0], viol}; BL2 CL2 tRP2 tRAS3
  localparam logic [12:0] VEC [NV] = '{
    {2'd1, 2'd0, 4'b1110, 4'b0000, 1'b0},
    {2'd0, 2'd0, 4'b1110, 4'b0000, 1'b0},
    {2'd0, 2'd0, 4'b1110, 4'b0000, 1'b0},
    {2'd2, 2'd0, 4'b1110, 4'b0000, 1'b0},
    {2'd0, 2'd0, 4'b1110, 4'b0000, 1'b0},
    {2'd0, 2'd0, 4'b1110, 4'b0001, 1'b0},
    {2'd0, 2'd0, 4'b1111, 4'b0000, 1'b0},
    {2'd1, 2'd0, 4'b1110, 4'b0000, 1'b0},
    {2'd1, 2'd1, 4'b1100, 4'b0000, 1'b0},
    {2'd0, 2'd0, 4'b1100, 4'b0000, 1'b0},
    {2'd3, 2'd0, 4'b1100, 4'b0000, 1'b0},
    {2'd0, 2'd0, 4'b1100, 4'b0000, 1'b0},
    {2'd2, 2'd1, 4'b1100, 4'b0001, 1'b0},
    {2'd0, 2'd0, 4'b1101, 4'b0000, 1'b0},
    {2'd0, 2'd0, 4'b1101, 4'b0010, 1'b0},
    {2'd0, 2'd0, 4'b1111, 4'b0000, 1'b0},
    {2'd0, 2'd0, 4'b1111, 4'b0000, 1'b0}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [1:0] c, input logic [1:0] b);
    @(negedge clk_i);
    cmd_i  = c;
    bank_i = b;
    @(posedge clk_i);
    #1;
    cmd_i = 2'd0;
  endtask

  task automatic clr_step(input logic [1:0] c, input logic [1:0] b);
    @(negedge clk_i);
    cmd_i  = c;
    bank_i = b;
    clr_i  = 1'b1;
    @(posedge clk_i);
    #1;
    cmd_i = 2'd0;
    clr_i = 1'b0;
  endtask

  task automatic cfg(input logic [2:0] bl, input logic sw, input logic c3,
                     input int trp, input int tras);
    @(negedge clk_i);
    bl_sel_i    = bl;
    single_wr_i = sw;
    cl3_i       = c3;
    trp_i       = CNT_W'(trp);
    tras_i      = CNT_W'(tras);
  endtask

  // expected timing computed from the requirement text
  task automatic run_ap(input logic [1:0] c, input logic [1:0] b, input logic [2:0] bl,
                        input logic sw, input logic c3, input int trp,
                        input logic [3:0] mask, input string tag);
    int beats;
    int start;
    int rel;
    beats = (bl < 3'd4) ? (1 << bl) : 0;
    if (c == 2'd3) start = (sw ? 1 : beats) + (c3 ? 1 : 0);
    else           start = beats;
    rel = start + trp;
    cfg(bl, sw, c3, trp, 1);
    dqm_i = mask;
    step(2'd1, b);
    step(c, b);
    chk(viol_o, 0, {tag, " legal command"});
    for (int j = 1; j < rel; j++) begin
      step(2'd0, b);
      chk(pre_start_o[b], (j == start), {tag, " precharge start"});
      chk(ready_o[b], (j == rel - 1), {tag, " release"});
    end
    step(2'd0, b);
    dqm_i = 4'h0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; cmd_i = 2'd0; bank_i = 2'd0; dqm_i = 4'h0; clr_i = 1'b0;
    bl_sel_i = 3'd1; single_wr_i = 1'b0; cl3_i = 1'b0; trp_i = 6'd2; tras_i = 6'd3;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk(ready_o, 4'hF, "R1 ready after reset");
    chk(pre_start_o, 4'h0, "R1 no precharge after reset");
    chk(viol_o, 0, "R1 no violation after reset");

    // table walk: R2 R3 R4 R11
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][12:11], VEC[i][10:9]);
      chk(ready_o, VEC[i][8:5], $sformatf("R2/R3 table %0d ready", i));
      chk(pre_start_o, VEC[i][4:1], $sformatf("R4/R11 table %0d pre_start", i));
      chk(viol_o, VEC[i][0], $sformatf("R2 table %0d viol", i));
    end

    cfg(3'd1, 1'b0, 1'b0, 2, 1);
    // R2 activate on open bank
    step(2'd1, 2'd0);
    step(2'd1, 2'd0);
    chk(viol_o, 1, "R2 activate open bank");
    chk(viol_bank_o, 0, "R2 violation bank");
    clr_step(2'd0, 2'd0);
    chk(viol_o, 0, "R10 clear");

    // R8 read on idle bank
    step(2'd2, 2'd3);
    chk(viol_o, 1, "R8 read on closed bank");
    chk(viol_bank_o, 3, "R8 bank index closed");
    clr_step(2'd0, 2'd0);

    // R8 command during auto-precharge
    step(2'd1, 2'd1);
    step(2'd2, 2'd1);
    step(2'd3, 2'd1);
    chk(viol_o, 1, "R8 write during auto-precharge");
    chk(viol_bank_o, 1, "R8 bank index busy");
    clr_step(2'd0, 2'd0);

    // R3 activate one clock early
    step(2'd1, 2'd2);
    step(2'd2, 2'd2);
    step(2'd0, 2'd0);
    step(2'd0, 2'd0);
    step(2'd1, 2'd2);
    chk(viol_o, 1, "R3 early activate");
    chk(viol_bank_o, 2, "R3 early activate bank");
    clr_step(2'd0, 2'd0);

    // R9 tRAS boundary
    cfg(3'd1, 1'b0, 1'b0, 2, 4);
    step(2'd1, 2'd1);
    step(2'd0, 2'd0);
    step(2'd2, 2'd1);
    chk(viol_o, 0, "R9 tRAS met exactly");
    step(2'd1, 2'd3);
    step(2'd2, 2'd3);
    chk(viol_o, 1, "R9 tRAS short");
    chk(viol_bank_o, 3, "R9 tRAS bank");

    // R10 first violation held, then same-cycle capture
    step(2'd1, 2'd0);
    chk(viol_bank_o, 3, "R10 first bank held");
    clr_step(2'd1, 2'd0);
    chk(viol_o, 1, "R10 capture with clear");
    chk(viol_bank_o, 0, "R10 captured bank");
    clr_step(2'd0, 2'd0);
    step(2'd2, 2'd0);
    repeat (8) step(2'd0, 2'd0);
    chk(ready_o, 4'hF, "R8 all banks released");
    chk(viol_o, 0, "R10 clean after clear");

    // R6 full page: auto-precharge ignored
    cfg(3'd7, 1'b0, 1'b0, 2, 1);
    step(2'd1, 2'd1);
    step(2'd2, 2'd1);
    chk(viol_o, 0, "R6 full-page read legal");
    for (int j = 0; j < 4; j++) begin
      step(2'd0, 2'd0);
      chk(ready_o[1], 0, "R6 bank stays open");
      chk(pre_start_o[1], 0, "R6 no precharge");
    end
    step(2'd3, 2'd1);
    chk(viol_o, 0, "R6 full-page write legal");
    chk(ready_o[1], 0, "R6 bank open after write");
    // R7 single write in full page does precharge: start 1, release 3
    cfg(3'd7, 1'b1, 1'b0, 2, 1);
    step(2'd3, 2'd1);
    step(2'd0, 2'd0);
    chk(pre_start_o[1], 1, "R7 full-page single write precharge");
    step(2'd0, 2'd0);
    chk(ready_o[1], 1, "R7 full-page single write release");
    step(2'd0, 2'd0);

    run_ap(2'd2, 2'd0, 3'd0, 1'b0, 1'b0, 1, 4'h0, "R3 BL1 tRP1");
    run_ap(2'd2, 2'd1, 3'd3, 1'b0, 1'b0, 3, 4'h0, "R3 BL8 tRP3");
    run_ap(2'd3, 2'd2, 3'd2, 1'b0, 1'b0, 2, 4'h0, "R4 BL4 CL2");
    run_ap(2'd3, 2'd3, 3'd2, 1'b0, 1'b1, 3, 4'h0, "R4 BL4 CL3");
    run_ap(2'd3, 2'd0, 3'd3, 1'b1, 1'b1, 2, 4'h0, "R7 single write CL3");
    run_ap(2'd3, 2'd1, 3'd1, 1'b0, 1'b1, 2, 4'hF, "R5 masked write");
    chk(viol_o, 0, "R5 no violation");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule